// File: doc/BRIEF.md
# Shared Interrupt and Output Port Section for a Dual-Channel Serial Controller

This block is the shared part of a two-channel serial controller that both channels use. It combines each channel's transmit-ready and receive-ready signals into one interrupt status byte. It gates that byte with a write-only enable mask and drives one active-low interrupt request line. The status byte and the mask share a single register address: a read returns the status and a write loads the mask.

The block also owns a general-purpose output port and an input port. Software never writes the output port as a whole byte. One address sets the selected bits and another clears them, so each channel's driver can change its own modem-control lines without a read-modify-write. A configuration register chooses, bit by bit, whether a pin follows the output-port register or an alternate on-chip function. The input port pins pass through a synchronizer and read back inverted, so a pin held low reads as an asserted signal.

The block uses a simple synchronous register bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `serial_irq_gpio`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) clears the interrupt mask, the output-port register and the pin configuration. After reset, `out_pins` is all ones and `irq_n` is 1.
- R2: A read at address 0x5 returns the unmasked status byte. Channel n's transmit-ready is at bit 4n and its receive-ready is at bit 4n+1, for n = 0 and 1. Bits 2, 3, 6 and 7 read 0.
- R3: A write at address 0x5 loads the mask from the write data. The mask cannot be read back, and writing it leaves the value read at 0x5 unchanged.
- R4: `irq_n` is a register. It is 0 in the cycle after any cycle in which (status AND mask) is nonzero, and 1 in the cycle after a cycle in which it is zero.
- R5: A write at address 0xE sets each output-port register bit whose write-data bit is 1 and leaves every other bit unchanged.
- R6: A write at address 0xF clears each output-port register bit whose write-data bit is 1 and leaves every other bit unchanged.
- R7: A write at address 0xD loads the pin configuration. Where a configuration bit is 0, that pin of `out_pins` carries the complement of the output-port register bit. Where it is 1, the pin carries the matching `alt_func` bit. Writing 0 gives every pin to the output-port register.
- R8: A read at address 0x4 returns the bitwise complement of `in_pins`, sampled through a two-stage synchronizer. The value shows a pin change after the second rising clock edge. Bit 7 reads 0.
- R9: Writes to any other address change neither the output pins nor the interrupt line. Reads of any address other than 0x4 and 0x5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tx_rdy | input | 2 | Transmit-ready source, one bit per channel |
| rx_rdy | input | 2 | Receive-ready source, one bit per channel |
| irq_n | output | 1 | Active-low interrupt request |
| in_pins | input | 7 | Input port pins (asynchronous) |
| alt_func | input | 8 | Alternate per-pin output values |
| out_pins | output | 8 | Output port pins |

## Verification
The table-driven part pairs each single-source pattern with a mask that either covers that source or misses it by one bit position. This shows that bit 4n and bit 4n+1 are placed correctly and are gated independently. A mixed pattern uses all four sources with a mask made only of unused status bits, which tells a correct AND apart from a plain "any source" OR. The directed part writes overlapping set and clear patterns so that a whole-byte load could not give the expected pins, and it measures the input-port latency edge by edge. The directed part also checks that writes to unused addresses and a mid-run reset act as required.

// File: rtl/irqio_pkg.sv
// Package: shared constants for the serial controller's common section.
// Assumes a 4-bit register address and an 8-bit data bus.
package irqio_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_INPORT = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_ISTAT  = 4'h5;
    localparam logic [ADDR_W-1:0] ADR_OCFG   = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_OSET   = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_OCLR   = 4'hF;

    // Nibble stride between channel fields in the status byte
    localparam int CH_STRIDE = 4;
endpackage

// File: rtl/irq_merge.sv
// irq_merge: builds the interrupt status byte from per-channel ready
// sources, holds the write-only mask and registers the active-low request.
// Assumes NCH * CH_STRIDE <= DATA_W. Sources are synchronous to clk.
module irq_merge
    import irqio_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCH-1:0]    tx_rdy,
    input  logic [NCH-1:0]    rx_rdy,
    output logic [DATA_W-1:0] status,
    output logic              irq_n
);
    logic [DATA_W-1:0] mask_q;

    // Place each channel's sources in its nibble; unused bits stay 0
    always_comb begin
        status = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            status[CH_STRIDE*ch]     = tx_rdy[ch];
            status[CH_STRIDE*ch + 1] = rx_rdy[ch];
        end
    end

    // Mask register, loaded by writes to the status address
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Registered request, low while any enabled source is active
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~|(status & mask_q);
    end

    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wdata)));
    a_r4_irq_assert: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & mask_q)) |=> !irq_n);
    a_r4_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & mask_q)) |=> irq_n);
    a_r1_mask_reset: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '0 && irq_n));
endmodule

// File: rtl/out_port.sv
// out_port: output-port register changed only by set and clear strobes,
// plus a per-pin configuration that picks register or alternate source.
// Assumes set and clear strobes never arrive in the same cycle.
module out_port #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             cfg_we,
    input  logic [OUT_W-1:0] wdata,
    input  logic [OUT_W-1:0] alt_func,
    output logic [OUT_W-1:0] pins
);
    logic [OUT_W-1:0] op_q;
    logic [OUT_W-1:0] cfg_q;

    // Bit-wise set or clear of the output-port register
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= '0;
        else if (set_we) op_q <= op_q | wdata;
        else if (clr_we) op_q <= op_q & ~wdata;
    end

    // Pin configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= wdata;
    end

    // Per-pin source selection; register bits drive pins inverted
    for (genvar i = 0; i < OUT_W; i++) begin : g_pin
        assign pins[i] = cfg_q[i] ? alt_func[i] : ~op_q[i];
    end

    a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((op_q & $past(wdata)) == $past(wdata)
                    && (op_q & ~$past(wdata)) == ($past(op_q) & ~$past(wdata))));
    a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((op_q & $past(wdata)) == '0
                    && (op_q & ~$past(wdata)) == ($past(op_q) & ~$past(wdata))));
    a_r9_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(op_q));
    a_r1_port_reset: assert property (@(posedge clk)
        !rst_n |=> (op_q == '0 && cfg_q == '0));
endmodule

// File: rtl/in_sync.sv
// in_sync: multi-stage synchronizer for asynchronous input pins.
// Presents the result in asserted-high sense (low pin reads as 1).
// Assumes STAGES >= 1; pins idle high, so reset fills the chain with ones.
module in_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] asserted
);
    logic [STAGES-1:0][W-1:0] chain_q;

    // First stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '1;
        else        chain_q[0] <= pins;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages shift the sample down the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign asserted = ~chain_q[STAGES-1];

    a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chain_q[0] == $past(pins)));
endmodule

// File: rtl/serial_irq_gpio.sv
// serial_irq_gpio: shared interrupt and I/O section of a dual-channel
// serial controller. Decodes the register bus into mask, set, clear and
// configuration strobes and muxes status and input-port read data.
// Assumes a single-cycle write strobe and combinational read data.
module serial_irq_gpio
    import irqio_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int OUT_W       = 8,
    parameter int IN_W        = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCH-1:0]    tx_rdy,
    input  logic [NCH-1:0]    rx_rdy,
    output logic              irq_n,
    input  logic [IN_W-1:0]   in_pins,
    input  logic [OUT_W-1:0]  alt_func,
    output logic [OUT_W-1:0]  out_pins
);
    logic              mask_we, set_we, clr_we, cfg_we;
    logic [DATA_W-1:0] status;
    logic [IN_W-1:0]   in_asserted;

    // Write strobe decode
    always_comb begin
        mask_we = bus_wr && (bus_addr == ADR_ISTAT);
        set_we  = bus_wr && (bus_addr == ADR_OSET);
        clr_we  = bus_wr && (bus_addr == ADR_OCLR);
        cfg_we  = bus_wr && (bus_addr == ADR_OCFG);
    end

    irq_merge #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .wdata   (bus_wdata),
        .tx_rdy  (tx_rdy),
        .rx_rdy  (rx_rdy),
        .status  (status),
        .irq_n   (irq_n)
    );

    out_port #(.OUT_W(OUT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .cfg_we   (cfg_we),
        .wdata    (bus_wdata[OUT_W-1:0]),
        .alt_func (alt_func),
        .pins     (out_pins)
    );

    in_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (in_pins),
        .asserted (in_asserted)
    );

    // Read data mux; unused addresses read zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADR_ISTAT:  bus_rdata = status;
            ADR_INPORT: bus_rdata[IN_W-1:0] = in_asserted;
            default:    bus_rdata = '0;
        endcase
    end

    a_r9_write_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mask_we, set_we, clr_we, cfg_we}));
endmodule

// File: tb/sim_serial_irq_gpio.sv
module sim_serial_irq_gpio;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] tx_rdy = 2'b00;
    logic [1:0] rx_rdy = 2'b00;
    logic       irq_n;
    logic [6:0] in_pins = 7'h7F;
    logic [7:0] alt_func = 8'h55;
    logic [7:0] out_pins;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    serial_irq_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_rdy(tx_rdy),
        .rx_rdy(rx_rdy), .irq_n(irq_n), .in_pins(in_pins),
        .alt_func(alt_func), .out_pins(out_pins)
    );

    // Vector: tx[1:0], rx[1:0], mask[7:0], expected status[7:0], expected irq_n
    localparam int NV = 9;
    localparam logic [NV-1:0][20:0] VEC = {
        {2'b00, 2'b10, 8'hFF, 8'h20, 1'b0},
        {2'b11, 2'b11, 8'hCC, 8'h33, 1'b1},
        {2'b10, 2'b10, 8'h20, 8'h30, 1'b0},
        {2'b10, 2'b00, 8'h0F, 8'h10, 1'b1},
        {2'b00, 2'b01, 8'h02, 8'h02, 1'b0},
        {2'b00, 2'b01, 8'h01, 8'h02, 1'b1},
        {2'b01, 2'b00, 8'h01, 8'h01, 1'b0},
        {2'b01, 2'b00, 8'h00, 8'h01, 1'b1},
        {2'b00, 2'b00, 8'hFF, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pins", out_pins, 8'hFF);
        check("R1 irq", {7'd0, irq_n}, 8'h01);
        rd_check("R2 idle status", 4'h5, 8'h00);
        rd_check("R8 idle input", 4'h4, 8'h00);

        // R2/R4: vector table
        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            wr(4'h5, v[16:9]);
            tx_rdy = v[20:19]; rx_rdy = v[18:17];
            @(negedge clk);
            check("R4 irq vector", {7'd0, irq_n}, {7'd0, v[0]});
            rd_check("R2 status vector", 4'h5, v[8:1]);
        end

        // R3: mask write leaves the status read unchanged
        tx_rdy = 2'b01; rx_rdy = 2'b00;
        wr(4'h5, 8'hAA);
        rd_check("R3 status after mask", 4'h5, 8'h01);
        @(negedge clk);
        check("R3 mask gates", {7'd0, irq_n}, 8'h01);

        // R5: set
        wr(4'hE, 8'h0F);
        check("R5 set low nibble", out_pins, 8'hF0);
        wr(4'hE, 8'h30);
        check("R5 set keeps others", out_pins, 8'hC0);
        // R6: clear
        wr(4'hF, 8'h05);
        check("R6 clear", out_pins, 8'hC5);
        // R7: configuration
        wr(4'hD, 8'h81);
        check("R7 alt pins", out_pins, 8'h45);
        alt_func = 8'hAA;
        #1 check("R7 alt follows", out_pins, 8'hC4);
        wr(4'hD, 8'h00);
        check("R7 cfg zero", out_pins, 8'hC5);

        // R8: input sync latency and inversion
        @(negedge clk);
        in_pins = 7'h05; bus_addr = 4'h4;
        @(posedge clk); #1;
        check("R8 one edge", bus_rdata, 8'h00);
        @(posedge clk); #1;
        check("R8 two edges", bus_rdata, 8'h7A);

        // R9: unused addresses
        wr(4'h6, 8'hFF);
        wr(4'hC, 8'hFF);
        wr(4'h4, 8'hFF);
        check("R9 pins unchanged", out_pins, 8'hC5);
        @(negedge clk);
        check("R9 irq unchanged", {7'd0, irq_n}, 8'h01);
        rd_check("R9 read unused", 4'h7, 8'h00);
        rd_check("R9 read 0E", 4'hE, 8'h00);
        rd_check("R9 input intact", 4'h4, 8'h7A);

        // R1: reset in mid-run
        wr(4'h5, 8'h01);
        @(negedge clk);
        check("R4 irq before reset", {7'd0, irq_n}, 8'h00);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R1 pins after reset", out_pins, 8'hFF);
        check("R1 irq after reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 mask cleared", {7'd0, irq_n}, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule